// File: doc/BRIEF.md
# Unsolicited Response Hold Buffer

This block sits on the codec side of a serial audio link, between the logic that raises unsolicited response requests and the transmitter that sends them to the host. In normal operation a request passes through with no added latency. When the link starts to enter its reset sequence, or the reset line drops on its own, the block stops releasing responses and stores each new request in an ordered queue. It keeps them there until the link is usable again.

While the reset line is low, the block emits a single power-state-change request strobe, followed one cycle later by an initialization request strobe. The reset line then returns high, and the link's initialization cycle hands the codec its unique address. The queued responses still stay held at that point. They are released only when the first command verb arrives after the address has been assigned. Software is still moving back to its active power state when the address arrives, so a response sent at that moment could be lost. The release uses a valid/ready handshake and moves one entry per accepted transfer. If a request arrives while the queue is full, it is discarded and a sticky overflow flag is set. The next verb clears that flag.

Top module: `unsol_hold_buf`

## Requirements
- R1: After reset, rsp_valid_o, pwr_chg_req_o, init_req_o and drop_flag_o are all 0.
- R2: A request presented in the cycle where link_rst_entry_i is 1, or in any later cycle before release, is queued and not offered (rsp_valid_o stays 0).
- R3: The reset line going low (link_rst_n_i = 0) with no prior entry detect also holds the queue and keeps rsp_valid_o at 0.
- R4: Each time the block goes from another state into the reset-low state, pwr_chg_req_o is 1 for exactly the one cycle after the low level is first sampled. init_req_o is 1 for exactly the following cycle. The two are never 1 together.
- R5: After the reset line returns high, rsp_valid_o stays 0 until the address pulse (addr_done_i). A verb that comes before that pulse, or in the same cycle as it, does not release the queue.
- R6: The first verb_rcvd_i strictly after the address pulse releases the queue. rsp_valid_o rises in the cycle after that verb is sampled.
- R7: Queued responses leave in arrival order, one entry per cycle where rsp_valid_o and rsp_ready_i are both 1. The queue holds DEPTH entries (default 8) of DATA_W bits (default 32).
- R8: A request that arrives while the queue is full and no entry leaves in that cycle is discarded. drop_flag_o becomes 1 in the next cycle and stays 1 until a verb is sampled, which clears it. If a discard and a verb happen in the same cycle, the flag is set.
- R9: When not holding and the queue is empty, a request appears on rsp_valid_o and rsp_data_o in the same cycle. If rsp_ready_i is 0, the request is stored and stays at the head of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_rst_entry_i | input | 1 | Link reset entry detected (pulse) |
| link_rst_n_i | input | 1 | Link reset line level, low = link in reset |
| addr_done_i | input | 1 | Unique address assigned by initialization cycle (pulse) |
| verb_rcvd_i | input | 1 | Command verb received (pulse) |
| req_valid_i | input | 1 | Unsolicited response request |
| req_data_i | input | DATA_W | Request payload |
| rsp_valid_o | output | 1 | Response offered to transmitter |
| rsp_data_o | output | DATA_W | Offered response payload |
| rsp_ready_i | input | 1 | Transmitter accepts the offered response |
| pwr_chg_req_o | output | 1 | Power state change request strobe |
| init_req_o | output | 1 | Initialization request strobe |
| drop_flag_o | output | 1 | Sticky flag: a request was discarded because the queue was full |

## Verification
The assertions check several rules on every cycle:
- no response is offered while an entry detect is present or the reset line is low;
- the initialization strobe always follows a power-change strobe, and the two never overlap;
- the block returns to running only through a verb sampled in the post-address state;
- the queue is never written when full or read when empty;
- the drop flag holds until a verb arrives.

Other behaviour can only be shown by the bench's scenarios:
- responses leave in the order they arrived;
- payloads survive backpressure;
- a verb before or together with the address pulse is ignored;
- exactly the first DEPTH requests survive an overflow.

// File: rtl/ursp_pkg.sv
package ursp_pkg;

    typedef enum logic [2:0] {
        LS_RUN   = 3'd0,
        LS_ENTRY = 3'd1,
        LS_RST   = 3'd2,
        LS_ADDR  = 3'd3,
        LS_VERB  = 3'd4
    } link_st_e;

    typedef struct packed {
        link_st_e st;
        logic     pwr;
        logic     init;
    } link_fsm_s;

endpackage

// File: rtl/ursp_link_fsm.sv
module ursp_link_fsm
    import ursp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic entry_i,
    input  logic link_rst_n_i,
    input  logic addr_done_i,
    input  logic verb_i,
    output logic release_o,
    output logic pwr_o,
    output logic init_o
);

    link_fsm_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pwr  = 1'b0;
        s_d.init = s_q.pwr;
        unique case (s_q.st)
            LS_RUN: begin
                if (!link_rst_n_i) begin
                    s_d.st  = LS_RST;
                    s_d.pwr = 1'b1;
                end else if (entry_i) begin
                    s_d.st = LS_ENTRY;
                end
            end
            LS_ENTRY: begin
                if (!link_rst_n_i) begin
                    s_d.st  = LS_RST;
                    s_d.pwr = 1'b1;
                end
            end
            LS_RST: begin
                if (link_rst_n_i) begin
                    s_d.st = LS_ADDR;
                end
            end
            LS_ADDR: begin
                if (!link_rst_n_i) begin
                    s_d.st  = LS_RST;
                    s_d.pwr = 1'b1;
                end else if (addr_done_i) begin
                    s_d.st = LS_VERB;
                end
            end
            LS_VERB: begin
                if (!link_rst_n_i) begin
                    s_d.st  = LS_RST;
                    s_d.pwr = 1'b1;
                end else if (verb_i) begin
                    s_d.st = LS_RUN;
                end
            end
            default: s_d.st = LS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: LS_RUN, pwr: 1'b0, init: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign release_o = (s_q.st == LS_RUN) && link_rst_n_i && !entry_i;
    assign pwr_o     = s_q.pwr;
    assign init_o    = s_q.init;

    AST_INIT_AFTER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> $past(pwr_o)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_o && init_o)); // R4
    AST_PWR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_o |-> !$past(link_rst_n_i)); // R4
    AST_RUN_VIA_VERB: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == LS_RUN && $past(s_q.st) != LS_RUN)
            |-> ($past(verb_i) && $past(s_q.st) == LS_VERB)); // R6

endmodule

// File: rtl/ursp_fifo.sv
module ursp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s f_d, f_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push_i) begin
            f_d.mem[f_q.wp] = din_i;
            f_d.wp          = ptr_inc(f_q.wp);
        end
        if (pop_i) begin
            f_d.rp = ptr_inc(f_q.rp);
        end
        unique case ({push_i, pop_i})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout_o  = f_q.mem[f_q.rp];
    assign empty_o = (f_q.cnt == '0);
    assign full_o  = (f_q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |-> pop_i); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH)); // R7

endmodule

// File: rtl/unsol_hold_buf.sv
module unsol_hold_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_rst_entry_i,
    input  logic              link_rst_n_i,
    input  logic              addr_done_i,
    input  logic              verb_rcvd_i,
    input  logic              req_valid_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    input  logic              rsp_ready_i,
    output logic              pwr_chg_req_o,
    output logic              init_req_o,
    output logic              drop_flag_o
);

    typedef struct packed {
        logic drop;
    } top_s;

    top_s t_d, t_q;

    logic              release_en;
    logic              q_empty, q_full;
    logic [DATA_W-1:0] q_head;
    logic              q_pop, q_push;
    logic              bypassed, want_push, dropped;

    ursp_link_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_i      (link_rst_entry_i),
        .link_rst_n_i (link_rst_n_i),
        .addr_done_i  (addr_done_i),
        .verb_i       (verb_rcvd_i),
        .release_o    (release_en),
        .pwr_o        (pwr_chg_req_o),
        .init_o       (init_req_o)
    );

    ursp_fifo #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .din_i   (req_data_i),
        .pop_i   (q_pop),
        .dout_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    always_comb begin
        rsp_valid_o = release_en && (!q_empty || req_valid_i);
        rsp_data_o  = q_empty ? req_data_i : q_head;
        q_pop       = release_en && !q_empty && rsp_ready_i;
        bypassed    = release_en && q_empty && req_valid_i && rsp_ready_i;
        want_push   = req_valid_i && !bypassed;
        q_push      = want_push && (!q_full || q_pop);
        dropped     = want_push && !q_push;

        t_d = t_q;
        if (dropped) begin
            t_d.drop = 1'b1;
        end else if (verb_rcvd_i) begin
            t_d.drop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign drop_flag_o = t_q.drop;

    AST_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst_entry_i |-> !rsp_valid_o); // R2
    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !link_rst_n_i |-> !rsp_valid_o); // R3
    AST_DROP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> drop_flag_o); // R8
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag_o && !verb_rcvd_i) |=> drop_flag_o); // R8
    AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drop_flag_o) |-> $past(req_valid_i)); // R8

endmodule

// File: tb/sim_unsol_hold_buf.sv
`timescale 1ns/1ps
module sim_unsol_hold_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_rst_entry_i = 1'b0;
    logic        link_rst_n_i = 1'b1;
    logic        addr_done_i = 1'b0;
    logic        verb_rcvd_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_data_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_data_o;
    logic        rsp_ready_i = 1'b0;
    logic        pwr_chg_req_o, init_req_o, drop_flag_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    unsol_hold_buf u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .link_rst_entry_i (link_rst_entry_i),
        .link_rst_n_i     (link_rst_n_i),
        .addr_done_i      (addr_done_i),
        .verb_rcvd_i      (verb_rcvd_i),
        .req_valid_i      (req_valid_i),
        .req_data_i       (req_data_i),
        .rsp_valid_o      (rsp_valid_o),
        .rsp_data_o       (rsp_data_o),
        .rsp_ready_i      (rsp_ready_i),
        .pwr_chg_req_o    (pwr_chg_req_o),
        .init_req_o       (init_req_o),
        .drop_flag_o      (drop_flag_o)
    );

    typedef struct packed {
        logic        req;
        logic [31:0] d;
        logic        rdy;
        logic        ev;
        logic [31:0] ed;
    } vec_t;

    // R9 / R7: bypass with empty queue, store under backpressure, keep order
    localparam vec_t TBL [8] = '{
        '{1'b1, 32'hA1, 1'b1, 1'b1, 32'hA1},
        '{1'b0, 32'h00, 1'b1, 1'b0, 32'h00},
        '{1'b1, 32'hA2, 1'b0, 1'b1, 32'hA2},
        '{1'b1, 32'hA3, 1'b0, 1'b1, 32'hA2},
        '{1'b0, 32'h00, 1'b1, 1'b1, 32'hA2},
        '{1'b1, 32'hA4, 1'b1, 1'b1, 32'hA3},
        '{1'b0, 32'h00, 1'b1, 1'b1, 32'hA4},
        '{1'b0, 32'h00, 1'b1, 1'b0, 32'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", 32'(rsp_valid_o), 32'd0);
        check("R1 pwr", 32'(pwr_chg_req_o), 32'd0);
        check("R1 init", 32'(init_req_o), 32'd0);
        check("R1 drop", 32'(drop_flag_o), 32'd0);

        // table walk: R9 bypass, R7 order
        foreach (TBL[i]) begin
            req_valid_i = TBL[i].req;
            req_data_i  = TBL[i].d;
            rsp_ready_i = TBL[i].rdy;
            #5;
            check("R9 table valid", 32'(rsp_valid_o), 32'(TBL[i].ev));
            if (TBL[i].ev) check("R7 table data", rsp_data_o, TBL[i].ed);
            @(negedge clk);
        end

        // R2: entry detect holds new requests
        link_rst_entry_i = 1'b1; req_valid_i = 1'b1; req_data_i = 32'hB1; rsp_ready_i = 1'b1;
        #5 check("R2 entry cycle", 32'(rsp_valid_o), 32'd0);
        @(negedge clk);
        link_rst_entry_i = 1'b0; req_data_i = 32'hB2;
        #5 check("R2 after entry", 32'(rsp_valid_o), 32'd0);
        @(negedge clk);
        link_rst_n_i = 1'b0; req_valid_i = 1'b0;
        @(negedge clk);
        check("R4 pwr strobe", 32'(pwr_chg_req_o), 32'd1);
        check("R4 init not yet", 32'(init_req_o), 32'd0);
        req_valid_i = 1'b1; req_data_i = 32'hB3;
        @(negedge clk);
        check("R4 pwr one cycle", 32'(pwr_chg_req_o), 32'd0);
        check("R4 init strobe", 32'(init_req_o), 32'd1);
        req_valid_i = 1'b0;
        @(negedge clk);
        check("R4 init one cycle", 32'(init_req_o), 32'd0);
        link_rst_n_i = 1'b1;
        @(negedge clk);
        verb_rcvd_i = 1'b1;
        #5 check("R5 verb before address", 32'(rsp_valid_o), 32'd0);
        @(negedge clk);
        addr_done_i = 1'b1; verb_rcvd_i = 1'b1;
        @(negedge clk);
        addr_done_i = 1'b0; verb_rcvd_i = 1'b0;
        #5 check("R5 held after address", 32'(rsp_valid_o), 32'd0);
        @(negedge clk);
        verb_rcvd_i = 1'b1;
        #5 check("R6 verb cycle still held", 32'(rsp_valid_o), 32'd0);
        @(negedge clk);
        verb_rcvd_i = 1'b0;
        #5 check("R6 released", 32'(rsp_valid_o), 32'd1);
        check("R7 first", rsp_data_o, 32'hB1);
        @(negedge clk);
        #5 check("R7 second", rsp_data_o, 32'hB2);
        @(negedge clk);
        #5 check("R7 third", rsp_data_o, 32'hB3);
        @(negedge clk);
        #5 check("R7 drained", 32'(rsp_valid_o), 32'd0);

        // R3 + R8: line drops with no entry detect, overflow the queue
        @(negedge clk);
        link_rst_n_i = 1'b0; req_valid_i = 1'b1; req_data_i = 32'hC000_0000;
        #5 check("R3 async hold", 32'(rsp_valid_o), 32'd0);
        for (int k = 1; k < 10; k++) begin
            @(negedge clk);
            req_data_i = 32'hC000_0000 + 32'(k);
        end
        @(negedge clk);
        req_valid_i = 1'b0;
        check("R8 drop flag set", 32'(drop_flag_o), 32'd1);
        check("R3 still held", 32'(rsp_valid_o), 32'd0);
        link_rst_n_i = 1'b1;
        @(negedge clk);
        addr_done_i = 1'b1;
        @(negedge clk);
        addr_done_i = 1'b0;
        @(negedge clk);
        check("R8 flag sticky", 32'(drop_flag_o), 32'd1);
        verb_rcvd_i = 1'b1;
        @(negedge clk);
        verb_rcvd_i = 1'b0;
        check("R8 flag cleared by verb", 32'(drop_flag_o), 32'd0);
        for (int i = 0; i < 8; i++) begin
            #5;
            check("R8 kept valid", 32'(rsp_valid_o), 32'd1);
            check("R7 kept order", rsp_data_o, 32'hC000_0000 + 32'(i));
            @(negedge clk);
        end
        #5 check("R8 extras dropped", 32'(rsp_valid_o), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule